// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page translations for a 32-bit address space. Each request carries a virtual address and an access kind: read, write or execute. The block compares the page-number half of the address against every stored entry in the same cycle. One cycle later it reports one of three outcomes. A hit returns the physical address. A miss tells a refill agent that it must produce the translation. A protection fault means the page is cached but the access kind is not allowed on it.

Each entry keeps the whole page descriptor: a modified flag, a referenced flag, a valid flag, a two-bit permission code and a 20-bit frame number. A lookup updates the two status flags in place. A refill agent installs new translations through a fill port, and a flush input empties the cache in one cycle.

Top module: `xlate_buf`

## Requirements
- R1: A virtual address splits into a page number (bits 31:12) and an offset (bits 11:0). On a hit, `rsp_paddr` is the stored 20-bit frame number joined to the unchanged offset; for example, 0xdeadbeef mapped to frame 0x002bb gives 0x002bbeef.
- R2: Any translation may occupy any entry, and all entries are compared at once. When several valid entries match, the lowest-indexed one answers.
- R3: A lookup with no matching valid entry reports `rsp_miss` and drives `rsp_paddr` and `rsp_flags` to zero. An entry filled with its valid bit clear never matches.
- R4: Access codes on `req_acc` are 00 read, 01 write, 10 execute, and 11 is never allowed. Permission codes are 00 no access, 01 read only, 10 read and write, 11 read and execute. A matching valid entry that does not allow the access reports `rsp_fault`, with `rsp_paddr` and `rsp_flags` equal to zero.
- R5: Each request produces exactly one response, registered one cycle later. In that response exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. `rsp_valid` is low in any cycle that follows a cycle without a request.
- R6: A hit sets the entry's referenced flag. A fault leaves both flags unchanged. `rsp_flags` = {modified, referenced} reports the entry's flags as they were before this lookup.
- R7: A permitted write sets the entry's modified flag. Reads and executes leave that flag unchanged.
- R8: The fill word `fill_pte` is packed from bit 24 down as: modified (24), referenced (23), valid (22), permission (21:20), frame number (19:0). A fill is stored as given, in the lowest-indexed entry whose valid bit is clear.
- R9: When every entry is valid, a fill replaces the entry named by a round-robin victim pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement.
- R10: A flush clears every valid bit and returns the victim pointer to entry 0 in one cycle. A fill in the same cycle is dropped.
- R11: After a synchronous reset, every entry is invalid, the victim pointer is at entry 0 and all response outputs are zero.
- R12: A lookup sees the table as it stood before the clock edge. A fill or flag update made in the same cycle is visible only to later lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind (00 read, 01 write, 10 execute) |
| fill_valid | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Page number of the installed translation |
| fill_pte | input | 25 | Descriptor of the installed translation |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_fault | output | 1 | Entry found but access not allowed |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |
| rsp_flags | output | 2 | {modified, referenced} before the lookup, on a hit |

## Verification
Every lookup outcome appears on the response port one clock edge after the request edge. Fills, flushes and flag updates take effect at the edge where they are driven, so the earliest lookup that can see them is the one presented in the following cycle. The driver presents each stimulus on a falling edge and queues the expected response at the same moment. The monitor compares on the next falling edge, which is one rising edge later. Status-flag effects, replacement order and flush effects are checked through the `rsp_flags`, hit and miss results of later lookups, whose cycle is known.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  parameter int VPN_W  = 20;
  parameter int OFF_W  = 12;
  parameter int PFN_W  = 20;
  parameter int PROT_W = 2;

  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PFN_W + OFF_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [PROT_W-1:0] {
    PROT_NONE = 2'b00,
    PROT_RO   = 2'b01,
    PROT_RW   = 2'b10,
    PROT_RX   = 2'b11
  } prot_e;

  typedef struct packed {
    logic              modified;
    logic              referenced;
    logic              valid;
    logic [PROT_W-1:0] prot;
    logic [PFN_W-1:0]  pfn;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/xlb_perm.sv
module xlb_perm
  import xlb_pkg::*;
(
  input  logic [PROT_W-1:0] prot,
  input  logic [1:0]        acc,
  output logic              allow
);
  always_comb begin
    allow = 1'b0;
    unique case (acc)
      ACC_READ:  allow = (prot == PROT_RO) || (prot == PROT_RW) || (prot == PROT_RX);
      ACC_WRITE: allow = (prot == PROT_RW);
      ACC_EXEC:  allow = (prot == PROT_RX);
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlb_match.sv
module xlb_match
  import xlb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][VPN_W-1:0] tags,
  input  logic [DEPTH-1:0]            valids,
  input  logic [VPN_W-1:0]            key,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = valids[g] && (tags[g] == key);
  end

  // Scan from the top so the lowest match is the last one written.
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign found = |eq;
endmodule

// File: rtl/xlb_slot_pick.sv
module xlb_slot_pick #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] valids,
  input  logic             fill_en,
  input  logic             flush,
  output logic [IDX_W-1:0] slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] victim_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valids[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&valids;
  assign slot     = any_free ? free_idx : victim_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      victim_q <= '0;
    end else if (fill_en && !any_free) begin
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_flags
);
  logic [DEPTH-1:0][VPN_W-1:0] tag_q;
  pte_t [DEPTH-1:0]            pte_q;
  logic [DEPTH-1:0]            valid_vec;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             found;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] fill_slot;
  pte_t             sel;
  logic             allow;
  logic             hit_c, miss_c, fault_c;
  logic             fill_en;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];
  assign fill_en = fill_valid && !flush;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign valid_vec[g] = pte_q[g].valid;
  end

  xlb_match #(.DEPTH(DEPTH)) u_match (
    .tags   (tag_q),
    .valids (valid_vec),
    .key    (req_vpn),
    .found  (found),
    .idx    (hit_idx)
  );

  assign sel = pte_q[hit_idx];

  xlb_perm u_perm (
    .prot  (sel.prot),
    .acc   (req_acc),
    .allow (allow)
  );

  xlb_slot_pick #(.DEPTH(DEPTH)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .valids  (valid_vec),
    .fill_en (fill_en),
    .flush   (flush),
    .slot    (fill_slot)
  );

  assign hit_c   = req_valid && found && allow;
  assign fault_c = req_valid && found && !allow;
  assign miss_c  = req_valid && !found;

  // Tags carry no reset; only valid bits gate a match.
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_slot] <= fill_vpn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pte_q <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) pte_q[i].valid <= 1'b0;
    end else begin
      if (hit_c) begin
        pte_q[hit_idx].referenced <= 1'b1;
        if (req_acc == ACC_WRITE) pte_q[hit_idx].modified <= 1'b1;
      end
      if (fill_en) pte_q[fill_slot] <= pte_t'(fill_pte);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_flags <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_c;
      rsp_miss  <= miss_c;
      rsp_fault <= fault_c;
      rsp_paddr <= hit_c ? {sel.pfn, req_off} : '0;
      rsp_flags <= hit_c ? {sel.modified, sel.referenced} : 2'b00;
    end
  end
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk
  import xlb_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_acc,
  input logic            flush,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_flags
);
  assert_req_gives_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_stray_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  assert_zero_unless_hit_R3: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0 && rsp_flags == 2'b00));

  assert_rsvd_never_hits_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_acc == ACC_RSVD) |=> !rsp_hit);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && req_valid) |=> rsp_miss);
endmodule

bind xlate_buf xlate_buf_chk u_chk (.*);

// File: tb/tb_xlate_buf.sv
module tb_xlate_buf;
  import xlb_pkg::*;

  typedef enum logic [1:0] {K_HIT, K_MISS, K_FAULT} kind_e;
  typedef struct {
    kind_e        kind;
    logic [31:0]  paddr;
    logic [1:0]   flags;
    string        req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [31:0]      req_vaddr = '0;
  logic [1:0]       req_acc = '0;
  logic             fill_valid = 1'b0;
  logic [19:0]      fill_vpn = '0;
  logic [24:0]      fill_pte = '0;
  logic             flush = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0]      rsp_paddr;
  logic [1:0]       rsp_flags;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  xlate_buf dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pte(fill_pte), .flush(flush), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags)
  );

  function automatic logic [24:0] mk(bit m, bit v, logic [1:0] prot, logic [19:0] pfn);
    return {m, 1'b0, v, prot, pfn};
  endfunction

  // Monitor: one response per queued item, compared one rising edge after the request.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R5: response with no request, hit=%0b miss=%0b fault=%0b expected none",
                 rsp_hit, rsp_miss, rsp_fault);
      end else begin
        exp_t e;
        kind_e got;
        e = sb.pop_front();
        got = rsp_hit ? K_HIT : (rsp_fault ? K_FAULT : K_MISS);
        if (got != e.kind || rsp_paddr != e.paddr || rsp_flags != e.flags ||
            $countones({rsp_hit, rsp_miss, rsp_fault}) != 1)
        begin
          fails++;
          $display("FAIL %s: got kind=%s paddr=%h flags=%b, expected kind=%s paddr=%h flags=%b",
                   e.req, got.name(), rsp_paddr, rsp_flags, e.kind.name(), e.paddr, e.flags);
        end
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input kind_e k,
                        input logic [31:0] pa, input logic [1:0] fl, input string req);
    exp_t e;
    e.kind = k; e.paddr = pa; e.flags = fl; e.req = req;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [24:0] pte);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11: reset state of the response port
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault} != 4'b0 || rsp_paddr != '0 || rsp_flags != '0) begin
      fails++;
      $display("FAIL R11: outputs valid=%b paddr=%h flags=%b, expected all zero",
               rsp_valid, rsp_paddr, rsp_flags);
    end
    lookup(32'h0000_0000, ACC_READ, K_MISS, '0, 2'b00, "R11");

    // R1, R6, R7: read/write flag tracking on a read-write page (slot 0)
    fill(20'hdeadb, mk(0, 1, PROT_RW, 20'h002bb));
    lookup(32'hdeadbeef, ACC_READ,  K_HIT, 32'h002bbeef, 2'b00, "R1");
    lookup(32'hdeadb004, ACC_READ,  K_HIT, 32'h002bb004, 2'b01, "R6");
    lookup(32'hdeadb100, ACC_WRITE, K_HIT, 32'h002bb100, 2'b01, "R7");
    lookup(32'hdeadbfff, ACC_READ,  K_HIT, 32'h002bbfff, 2'b11, "R7");

    // R4: permission checks (slots 1..3)
    fill(20'h49381, mk(0, 1, PROT_RO, 20'h00200));
    lookup(32'h49381abc, ACC_READ,  K_HIT,   32'h00200abc, 2'b00, "R4");
    lookup(32'h49381abc, ACC_WRITE, K_FAULT, '0, 2'b00, "R4");
    lookup(32'h49381000, ACC_READ,  K_HIT,   32'h00200000, 2'b01, "R6");
    lookup(32'h49381000, ACC_EXEC,  K_FAULT, '0, 2'b00, "R4");
    lookup(32'h49381000, 2'b11,     K_FAULT, '0, 2'b00, "R4");
    fill(20'hab790, mk(0, 1, PROT_NONE, 20'h0025b));
    lookup(32'hab790010, ACC_READ,  K_FAULT, '0, 2'b00, "R4");
    fill(20'hef455, mk(0, 1, PROT_RX, 20'h004f8));
    lookup(32'hef455222, ACC_WRITE, K_FAULT, '0, 2'b00, "R4");
    lookup(32'hef455222, ACC_EXEC,  K_HIT, 32'h004f8222, 2'b00, "R6");
    lookup(32'hef455333, ACC_READ,  K_HIT, 32'h004f8333, 2'b01, "R6");

    // R3, R8: invalid fill never matches and its slot is reused (slot 4)
    fill(20'h978b2, mk(0, 0, PROT_RW, 20'h0030f));
    lookup(32'h978b2000, ACC_READ, K_MISS, '0, 2'b00, "R3");
    fill(20'h978b2, mk(1, 1, PROT_RW, 20'h0030f));
    lookup(32'h978b2444, ACC_READ, K_HIT, 32'h0030f444, 2'b10, "R8");

    // R2: duplicate in slot 5, lower slot 0 answers
    fill(20'hdeadb, mk(0, 1, PROT_RW, 20'h00111));
    lookup(32'hdeadb555, ACC_READ, K_HIT, 32'h002bb555, 2'b11, "R2");

    // R12: lookup concurrent with its own fill misses, next one hits (slot 6)
    fill_valid = 1'b1; fill_vpn = 20'h12345; fill_pte = mk(0, 1, PROT_RW, 20'h00345);
    lookup(32'h12345678, ACC_READ, K_MISS, '0, 2'b00, "R12");
    fill_valid = 1'b0;
    lookup(32'h12345678, ACC_READ, K_HIT, 32'h00345678, 2'b00, "R12");

    // R8: fill remaining slots 7..63
    for (int i = 0; i < 57; i++) fill(20'h00100 + 20'(i), mk(0, 1, PROT_RW, 20'h00800 + 20'(i)));
    lookup(32'h00138abc, ACC_READ, K_HIT, 32'h00838abc, 2'b00, "R8");

    // R9: full table, victims go 0 then 1
    fill(20'haaaaa, mk(0, 1, PROT_RW, 20'h00aaa));
    lookup(32'hdeadb123, ACC_READ, K_HIT, 32'h00111123, 2'b00, "R9");
    lookup(32'haaaaa001, ACC_READ, K_HIT, 32'h00aaa001, 2'b00, "R9");
    fill(20'hbbbbb, mk(0, 1, PROT_RW, 20'h00bbb));
    lookup(32'h49381000, ACC_READ, K_MISS, '0, 2'b00, "R9");
    lookup(32'hef455000, ACC_EXEC, K_HIT, 32'h004f8000, 2'b01, "R9");

    // R10: flush with concurrent fill
    flush = 1'b1;
    fill(20'hccccc, mk(0, 1, PROT_RW, 20'h00ccc));
    flush = 1'b0;
    lookup(32'haaaaa000, ACC_READ, K_MISS, '0, 2'b00, "R10");
    lookup(32'hccccc000, ACC_READ, K_MISS, '0, 2'b00, "R10");
    lookup(32'h00100000, ACC_READ, K_MISS, '0, 2'b00, "R10");

    // R10: victim pointer back at 0 after refilling the whole table
    for (int i = 0; i < 64; i++) fill(20'h00200 + 20'(i), mk(0, 1, PROT_RW, 20'h00900 + 20'(i)));
    fill(20'hddddd, mk(0, 1, PROT_RW, 20'h00ddd));
    lookup(32'h00200000, ACC_READ, K_MISS, '0, 2'b00, "R10");
    lookup(32'h00202010, ACC_READ, K_HIT, 32'h00902010, 2'b00, "R10");
    lookup(32'h00201020, ACC_READ, K_HIT, 32'h00901020, 2'b00, "R9");
    lookup(32'hddddd777, ACC_READ, K_HIT, 32'h00ddd777, 2'b00, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule